// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This block carries out a multi-register load or store as a run of single-word memory accesses. It is started with a 32-bit instruction word and the current value of the base register. The instruction word supplies the register list, the base register index and four control bits. The sequencer then walks the list from the lowest register index to the highest and issues one word access per selected register over a request/ready memory port.

For a store, the sequencer names the register it needs on a read-index output and forwards the register-file data to memory as the write data. For a load, it returns each fetched word together with its register index on a write port to the register file. When base update is requested, it also computes the updated base value and writes it back in the final cycle, together with a one-cycle completion pulse.

The register file and the memory sit outside the block. The block holds only the remaining-list mask, the running address and the writeback details.

Top module: `bx_seq`

## Requirements
- R1: The instruction fields are decoded as follows: bit 24 selects pre-indexing (1) or post-indexing (0); bit 23 selects up (1) or down (0); bit 21 requests base writeback; bit 20 selects load (1) or store (0); bits 19:16 hold the base register index; bits 15:0 hold the register list, where bit i selects register i.
- R2: With n set bits in the list, the first access address depends on the mode. Up and post-indexed starts at base. Up and pre-indexed starts at base+4. Down and pre-indexed starts at base−4n. Down and post-indexed starts at base−4n+4.
- R3: Registers are transferred in ascending index order. The read index names the register of the current access, and each completed access raises the address by 4, in both directions.
- R4: With writeback requested and a non-empty list, the done cycle carries a register write of base+4n (up) or base−4n (down) to the base register index.
- R5: For a load, each word accepted from memory is written to its register one cycle after the accepting cycle. For a store, mem_we is high and mem_wdata equals rf_rd_data for the register named on rf_rd_idx, and no register write occurs before done.
- R6: mem_req stays high with a stable address until mem_ready is seen, and at most one access completes per cycle. done is a single-cycle pulse two cycles after the cycle of the last completed access, and mem_req is low from the cycle after that access onward.
- R7: An empty list makes no memory request and no register write, and done is high in the cycle after start is taken.
- R8: A load whose list contains the base register produces no writeback write, even with writeback requested, so the loaded word stays in the base register.
- R9: start is taken only while busy is low. busy is high from the cycle after start until done, and a start pulse while busy has no effect on the running transfer.
- R10: After reset, busy, done, mem_req and rf_wr_en are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken when idle) |
| instr | input | 32 | Instruction word with list, base index and control bits |
| base_val | input | ADDR_W | Current value of the base register |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write (store) |
| mem_addr | output | ADDR_W | Word address of the current access |
| mem_wdata | output | DATA_W | Store data |
| mem_rdata | input | DATA_W | Load data, valid while mem_ready is high |
| mem_ready | input | 1 | Memory completes the current access this cycle |
| rf_rd_idx | output | 4 | Register being transferred |
| rf_rd_data | input | DATA_W | Register-file value of rf_rd_idx |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wr_idx | output | 4 | Register-file write index |
| rf_wr_data | output | DATA_W | Register-file write data |

## Verification
If the remaining-list mask is corrupted, the error shows on rf_rd_idx in the next request cycle as a skipped, repeated or out-of-order index. The beat count at done is then also wrong. A wrong address register shows in mem_addr on the same cycle, and stores and loads then land at the wrong memory word, so the mismatch appears at the first affected access. A wrong latched mode, base index or writeback flag stays hidden until the done cycle, where the writeback write is missing, spurious or carries the wrong value.

// File: rtl/bx_pkg.sv
package bx_pkg;
    localparam int NREG    = 16;
    localparam int IDX_W   = $clog2(NREG);
    localparam int CNT_W   = $clog2(NREG + 1);
    localparam int POS_PRE = 24;
    localparam int POS_UP  = 23;
    localparam int POS_WB  = 21;
    localparam int POS_LD  = 20;
    localparam int POS_BASE = 16;
    localparam int POS_LIST = 0;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FINAL = 2'd2
    } bx_state_e;
endpackage

// File: rtl/bx_popcount.sv
module bx_popcount #(
    parameter int W   = 16,
    parameter int C_W = $clog2(W + 1)
) (
    input  logic [W-1:0]   vec,
    output logic [C_W-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + C_W'(vec[i]);
        end
    end
endmodule

// File: rtl/bx_lsb_pick.sv
module bx_lsb_pick #(
    parameter int W   = 16,
    parameter int I_W = $clog2(W)
) (
    input  logic [W-1:0]   vec,
    output logic [W-1:0]   onehot,
    output logic [I_W-1:0] idx,
    output logic           last
);
    logic [W-1:0] below;

    assign below[0] = 1'b0;
    for (genvar i = 1; i < W; i++) begin : g_prefix
        assign below[i] = below[i-1] | vec[i-1];
    end

    assign onehot = vec & ~below;
    assign last   = (vec != '0) && ((vec & ~onehot) == '0);

    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (onehot[i]) idx = idx | I_W'(i);
        end
    end
endmodule

// File: rtl/bx_addr_calc.sv
module bx_addr_calc #(
    parameter int A_W = 32,
    parameter int C_W = 5
) (
    input  logic [A_W-1:0] base,
    input  logic [C_W-1:0] cnt,
    input  logic           pre,
    input  logic           up,
    output logic [A_W-1:0] first,
    output logic [A_W-1:0] wb_val
);
    localparam logic [A_W-1:0] STEP = A_W'(4);
    logic [A_W-1:0] span;

    assign span = A_W'(cnt) << 2;

    always_comb begin
        if (up) begin
            first  = pre ? base + STEP : base;
            wb_val = base + span;
        end else begin
            first  = pre ? base - span : base - span + STEP;
            wb_val = base - span;
        end
    end
endmodule

// File: rtl/bx_seq.sv
module bx_seq
    import bx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       instr,
    input  logic [ADDR_W-1:0] base_val,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [IDX_W-1:0]  rf_rd_idx,
    input  logic [DATA_W-1:0] rf_rd_data,
    output logic              rf_wr_en,
    output logic [IDX_W-1:0]  rf_wr_idx,
    output logic [DATA_W-1:0] rf_wr_data
);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

    typedef struct packed {
        bx_state_e         st;
        logic [NREG-1:0]   mask;
        logic [ADDR_W-1:0] addr;
        logic              load;
        logic              wb_en;
        logic [IDX_W-1:0]  base_idx;
        logic [ADDR_W-1:0] wb_val;
        logic              done;
        logic              wr_en;
        logic [IDX_W-1:0]  wr_idx;
        logic [DATA_W-1:0] wr_data;
    } bx_regs_t;

    bx_regs_t r_d, r_q;

    // instruction fields
    logic [NREG-1:0]  f_list;
    logic [IDX_W-1:0] f_base;
    logic             f_pre, f_up, f_wb, f_ld;
    logic             unused_instr_bits;

    assign f_list = instr[POS_LIST +: NREG];
    assign f_base = instr[POS_BASE +: IDX_W];
    assign f_pre  = instr[POS_PRE];
    assign f_up   = instr[POS_UP];
    assign f_wb   = instr[POS_WB];
    assign f_ld   = instr[POS_LD];
    assign unused_instr_bits = ^{instr[31:25], instr[22]};

    logic [CNT_W-1:0]  list_cnt;
    logic [ADDR_W-1:0] first_addr, wb_addr;
    logic [NREG-1:0]   pick_oh;
    logic [IDX_W-1:0]  pick_idx;
    logic              pick_last;

    bx_popcount #(.W(NREG), .C_W(CNT_W)) u_cnt (
        .vec (f_list),
        .cnt (list_cnt)
    );

    bx_addr_calc #(.A_W(ADDR_W), .C_W(CNT_W)) u_addr (
        .base   (base_val),
        .cnt    (list_cnt),
        .pre    (f_pre),
        .up     (f_up),
        .first  (first_addr),
        .wb_val (wb_addr)
    );

    bx_lsb_pick #(.W(NREG), .I_W(IDX_W)) u_pick (
        .vec    (r_q.mask),
        .onehot (pick_oh),
        .idx    (pick_idx),
        .last   (pick_last)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.wr_en = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.mask     = f_list;
                    r_d.addr     = first_addr;
                    r_d.load     = f_ld;
                    r_d.base_idx = f_base;
                    r_d.wb_val   = wb_addr;
                    r_d.wb_en    = f_wb && !(f_ld && f_list[f_base]);
                    if (f_list == '0) r_d.done = 1'b1;
                    else              r_d.st   = ST_RUN;
                end
            end
            ST_RUN: begin
                if (mem_ready) begin
                    r_d.mask = r_q.mask & ~pick_oh;
                    r_d.addr = r_q.addr + WORD_STEP;
                    if (r_q.load) begin
                        r_d.wr_en   = 1'b1;
                        r_d.wr_idx  = pick_idx;
                        r_d.wr_data = mem_rdata;
                    end
                    if (pick_last) r_d.st = ST_FINAL;
                end
            end
            ST_FINAL: begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
                if (r_q.wb_en) begin
                    r_d.wr_en   = 1'b1;
                    r_d.wr_idx  = r_q.base_idx;
                    r_d.wr_data = DATA_W'(r_q.wb_val);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy       = (r_q.st != ST_IDLE);
    assign done       = r_q.done;
    assign mem_req    = (r_q.st == ST_RUN);
    assign mem_we     = mem_req && !r_q.load;
    assign mem_addr   = r_q.addr;
    assign mem_wdata  = rf_rd_data;
    assign rf_rd_idx  = pick_idx;
    assign rf_wr_en   = r_q.wr_en;
    assign rf_wr_idx  = r_q.wr_idx;
    assign rf_wr_data = r_q.wr_data;

    // assertions
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ready && !pick_last |=> mem_req && (mem_addr == $past(mem_addr) + WORD_STEP));

    p_idx_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ready && !pick_last |=> rf_rd_idx > $past(rf_rd_idx));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(rf_rd_idx));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_store_nowr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en && !done |-> $past(mem_req && mem_ready && !mem_we));

    p_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start && (instr[15:0] == 16'h0) |=> done && !mem_req && !rf_wr_en);
endmodule

// File: tb/bx_seq_tb.sv
`timescale 1ns/1ps
module bx_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [31:0] instr;
    logic [31:0] base_val;
    logic        busy, done, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready;
    logic [3:0]  rf_rd_idx;
    logic [31:0] rf_rd_data;
    logic        rf_wr_en;
    logic [3:0]  rf_wr_idx;
    logic [31:0] rf_wr_data;

    logic [31:0] mem [64];
    logic [31:0] rf  [16];

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    assign mem_rdata  = mem[mem_addr[7:2]];
    assign rf_rd_data = rf[rf_rd_idx];

    bx_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .base_val(base_val),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int popc(input logic [15:0] v);
        int c = 0;
        for (int i = 0; i < 16; i++) c += int'(v[i]);
        return c;
    endfunction

    // R2 start address
    function automatic logic [31:0] exp_first(input logic [31:0] b, input int n, input bit pre, input bit up);
        if (up) return pre ? b + 32'd4 : b;
        return pre ? b - 32'(4 * n) : b - 32'(4 * n) + 32'd4;
    endfunction

    // R4 writeback value
    function automatic logic [31:0] exp_wbv(input logic [31:0] b, input int n, input bit up);
        return up ? b + 32'(4 * n) : b - 32'(4 * n);
    endfunction

    function automatic logic [31:0] mk_instr(input bit pre, input bit up, input bit wb, input bit ld,
                                             input logic [3:0] bidx, input logic [15:0] list);
        logic [31:0] w = 32'hE800_0000;
        w[24] = pre; w[23] = up; w[21] = wb; w[20] = ld;
        w[19:16] = bidx; w[15:0] = list;
        return w;
    endfunction

    task automatic run_op(input logic [31:0] ins, input logic [31:0] base, input int rdy_pct, input bit poke);
        logic [15:0] list = ins[15:0];
        logic [15:0] rem  = ins[15:0];
        int  cnt  = popc(list);
        bit  pre  = ins[24], up = ins[23], wbr = ins[21], ld = ins[20];
        logic [3:0]  bidx  = ins[19:16];
        logic [31:0] first = exp_first(base, cnt, pre, up);
        logic [31:0] wbv   = exp_wbv(base, cnt, up);
        bit  exp_wb = wbr && (cnt != 0) && !(ld && list[bidx]);
        int  beat = 0;
        int  done_cyc = (cnt == 0) ? 0 : 100000;
        bit  pend = 0;
        logic [3:0]  pend_idx = '0;
        logic [31:0] pend_data = '0;
        bit  fin = 0;

        @(negedge clk);
        start = 1'b1; instr = ins; base_val = base; mem_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < 400 && !fin; cyc++) begin
            bit rdy = 0;
            if (poke && cyc == 1) begin start = 1'b1; instr = $urandom; base_val = $urandom; end
            if (poke && cyc == 2) start = 1'b0;
            if (done) begin
                chk(cyc == done_cyc, "R6 done cycle", cyc, done_cyc);
                chk(beat == cnt, "R3 beat count", beat, cnt);
                if (exp_wb) begin
                    chk(rf_wr_en && rf_wr_idx == bidx && rf_wr_data == wbv, "R4 writeback", rf_wr_data, wbv);
                end else if (ld && wbr && list[bidx]) begin
                    chk(!rf_wr_en, "R8 no writeback over load", rf_wr_en, 0);
                end else begin
                    chk(!rf_wr_en, "R7 no register write", rf_wr_en, 0);
                end
                if (rf_wr_en) rf[rf_wr_idx] = rf_wr_data;
                chk(!busy && !mem_req, "R9 idle at done", busy, 0);
                fin = 1;
            end else begin
                chk(busy, "R9 busy during transfer", busy, 1);
                if (pend) begin
                    chk(rf_wr_en && rf_wr_idx == pend_idx && rf_wr_data == pend_data,
                        "R5 load write", rf_wr_data, pend_data);
                    if (rf_wr_en) rf[rf_wr_idx] = rf_wr_data;
                    pend = 0;
                end else begin
                    chk(!rf_wr_en, "R5 unexpected write", rf_wr_en, 0);
                end
                if (beat < cnt) begin
                    logic [3:0]  eidx = '0;
                    logic [31:0] eaddr = first + 32'(4 * beat);
                    for (int i = 15; i >= 0; i--) if (rem[i]) eidx = 4'(i);
                    chk(mem_req, "R6 request held", mem_req, 1);
                    chk(mem_addr == eaddr, "R1 R2 R3 address", mem_addr, eaddr);
                    chk(rf_rd_idx == eidx, "R3 order", rf_rd_idx, eidx);
                    chk(mem_we == !ld, "R5 direction", mem_we, !ld);
                    if (!ld) chk(mem_wdata == rf[eidx], "R5 store data", mem_wdata, rf[eidx]);
                    rdy = (($urandom % 100) < rdy_pct);
                    if (rdy) begin
                        if (ld) begin pend = 1; pend_idx = eidx; pend_data = mem[eaddr[7:2]]; end
                        else mem[eaddr[7:2]] = rf[eidx];
                        rem[eidx] = 1'b0;
                        beat++;
                        if (beat == cnt) done_cyc = cyc + 2;
                    end
                end else begin
                    chk(!mem_req, "R6 request after last", mem_req, 0);
                end
            end
            mem_ready = rdy;
            if (!fin) @(negedge clk);
        end
        chk(fin, "R6 completion", fin, 1);
        mem_ready = 1'b0;
        start = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EC0_0042);
        rst_n = 1'b0; start = 1'b0; instr = '0; base_val = '0; mem_ready = 1'b0;
        for (int i = 0; i < 64; i++) mem[i] = $urandom;
        for (int i = 0; i < 16; i++) rf[i] = $urandom;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !mem_req && !rf_wr_en, "R10 reset state", {busy, done, mem_req, rf_wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_req && !rf_wr_en, "R10 idle after reset", {busy, done, mem_req, rf_wr_en}, 0);

        // R1 R2: each mode, fixed list
        run_op(mk_instr(0, 1, 1, 1, 4'd13, 16'h00F0), 32'h0000_0100, 100, 0);
        run_op(mk_instr(1, 1, 1, 0, 4'd13, 16'h8421), 32'h0000_0040, 70, 0);
        run_op(mk_instr(1, 0, 1, 0, 4'd2,  16'hFFFF), 32'h0000_0080, 60, 0);
        run_op(mk_instr(0, 0, 1, 1, 4'd3,  16'h000E), 32'h0000_0020, 50, 0);
        // R7 empty list with writeback
        run_op(mk_instr(1, 1, 1, 1, 4'd5,  16'h0000), 32'h0000_0010, 100, 0);
        // R8 load including base with writeback
        run_op(mk_instr(1, 0, 1, 1, 4'd6,  16'h00C1), 32'h0000_0090, 80, 0);
        // store including base with writeback still writes back (R4)
        run_op(mk_instr(0, 1, 1, 0, 4'd6,  16'h00C1), 32'h0000_0030, 80, 0);
        // R9 start while busy, slow memory
        run_op(mk_instr(0, 1, 0, 1, 4'd1,  16'h1234), 32'h0000_0008, 30, 1);
        // single register, R6 timing
        run_op(mk_instr(1, 1, 0, 0, 4'd0,  16'h0001), 32'h0000_00FC, 100, 0);
        run_op(mk_instr(0, 0, 1, 1, 4'd15, 16'h8000), 32'h0000_0004, 40, 0);

        for (int k = 0; k < 60; k++) begin
            logic [31:0] w = $urandom;
            if (k % 9 == 0) w[15:0] = 16'h0;
            run_op(w, {$urandom} & 32'hFFFF_FFFC, 20 + ($urandom % 81), (k % 7 == 0));
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule